// File: doc/BRIEF.md
# Serial Register Bank Front End

This block is a serial slave front end that gives an external host access to a bank of sixteen byte-wide registers. The host raises an active-high chip enable, sends a command byte that selects read or write and names a starting register, and then moves any number of data bytes. After each data byte the register pointer steps to the next register, and it wraps from the last register back to the first. All serial inputs are resynchronised and oversampled by the system clock. Incoming bits are taken on serial clock rising edges, and outgoing bits change on falling edges.

A write of one guarded byte value to register 0 is treated as a command, not as data. It produces a one-cycle reset pulse for the surrounding design and leaves register 0 as it was. While chip enable is high the block raises an access flag, so that neighbouring counters can hold still during a transfer. The serial output comes with an enable, so that a pad can tristate it and share one wire between the directions.

Top module: `spi_regbank`

## Requirements
- R1: The command byte is shifted in MSB first. Bit 7 = 1 selects read and 0 selects write, bits 6:4 must equal 001, and bits 3:0 give the starting register address.
- R2: Write data bytes are taken MSB first, one bit per serial clock rising edge, and stored in the addressed register.
- R3: The register pointer advances by one after every data byte, in both reads and writes, and wraps from Fh to 0h.
- R4: A write of 58h to register 0 emits a reset pulse exactly one system clock long and leaves register 0 unchanged. Any other value written to register 0 is stored. 58h written to any other register is stored and emits no pulse.
- R5: Bits that are not implemented read back as 0. By default register 5 keeps only bits 5:0 (mask 3Fh) and register 6 keeps only bits 2:0 (mask 07h). All other registers keep all 8 bits.
- R6: Read data for the current register is loaded at the first serial clock falling edge of each byte. It is shifted out MSB first and changes only on falling edges.
- R7: The output enable is high only during the data phase of a valid read while chip enable is high. It stays low during writes and during command bytes.
- R8: Dropping chip enable at any point, including mid-byte, discards the partial byte and returns the interface to the command phase.
- R9: A command whose bits 6:4 are not 001 causes the rest of that transfer to be ignored: no register is written and the output is never enabled.
- R10: The access flag follows chip enable, delayed by the input synchroniser plus one register.
- R11: After synchronous reset, the output enable, the access flag and the reset pulse are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cs_en | input | 1 | Chip enable, active high |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block, forced low when not enabled |
| miso_oe | output | 1 | Drive enable for the serial output pad |
| busy | output | 1 | Access-active flag for freezing neighbouring counters |
| swrst | output | 1 | One-cycle software reset pulse |

## Verification
Single-byte write-then-read pairs are taken from a vector table. They separate plain storage, masking of unimplemented bits, and the guarded reset value arriving at the wrong register or as the wrong value at register 0. Multi-byte bursts that start near the top of the map show whether the pointer wraps and whether read data is refetched for every byte. Commands with a wrong subaddress, and a transfer aborted mid-byte, show whether stray traffic can corrupt storage, drive the output line, or leave the bit counter out of step with the next command.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2,
    PH_IGN = 2'd3
  } phase_t;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_in,
  input  logic sclk_in,
  input  logic mosi_in,
  output logic cs_s,
  output logic mosi_s,
  output logic sclk_rise,
  output logic sclk_fall
);
  logic [STAGES-1:0] cs_p, sk_p, mo_p;
  logic sk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p <= '0;
      sk_p <= '0;
      mo_p <= '0;
      sk_d <= 1'b0;
    end else begin
      cs_p <= {cs_p[STAGES-2:0], cs_in};
      sk_p <= {sk_p[STAGES-2:0], sclk_in};
      mo_p <= {mo_p[STAGES-2:0], mosi_in};
      sk_d <= sk_p[STAGES-1];
    end
  end

  assign cs_s      = cs_p[STAGES-1];
  assign mosi_s    = mo_p[STAGES-1];
  assign sclk_rise = cs_s &  sk_p[STAGES-1] & ~sk_d;
  assign sclk_fall = cs_s & ~sk_p[STAGES-1] &  sk_d;
endmodule

// File: rtl/spi_rb_shift.sv
module spi_rb_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_s,
  input  logic         rise,
  input  logic         fall,
  input  logic         mosi_s,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  output logic         byte_done,
  output logic [W-1:0] rx_byte,
  output logic         tx_bit
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;
  logic [W-1:0]  tx;

  always_ff @(posedge clk) begin
    if (rst || !cs_s) begin
      cnt       <= '0;
      sh        <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (rise) begin
        sh  <= {sh[W-2:0], mosi_s};
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        if (cnt == LAST) begin
          byte_done <= 1'b1;
          rx_byte   <= {sh[W-2:0], mosi_s};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_s) begin
      tx <= '0;
    end else if (fall) begin
      tx <= load ? ld_data : {tx[W-2:0], 1'b0};
    end
  end

  assign tx_bit = tx[W-1];

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> (cnt == '0)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> !byte_done); // R2
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [DW-2-AW:0] SUB_VAL = 3'b001,
  parameter logic [DW-1:0] SWRST_CODE = 8'h58,
  parameter logic [DW*(1<<AW)-1:0] IMPL_MASK =
    {{9{8'hFF}}, 8'h07, 8'h3F, {5{8'hFF}}}
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_en,
  input  logic sclk,
  input  logic mosi,
  output logic miso,
  output logic miso_oe,
  output logic busy,
  output logic swrst
);
  import spi_rb_pkg::*;

  localparam int DEPTH = 1 << AW;

  logic          cs_s, mosi_s, rise, fall;
  logic          byte_done, tx_bit;
  logic [DW-1:0] rx_byte;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;
  logic [AW-1:0] addr_q;
  logic          load_pend;
  phase_t        phase;
  logic          is_guard, wr_en;

  spi_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_in(cs_en), .sclk_in(sclk), .mosi_in(mosi),
    .cs_s(cs_s), .mosi_s(mosi_s), .sclk_rise(rise), .sclk_fall(fall)
  );

  spi_rb_shift #(.W(DW)) u_shift (
    .clk(clk), .rst(rst), .cs_s(cs_s), .rise(rise), .fall(fall),
    .mosi_s(mosi_s), .load(load_pend), .ld_data(rd_q),
    .byte_done(byte_done), .rx_byte(rx_byte), .tx_bit(tx_bit)
  );

  assign is_guard = (addr_q == '0) && (rx_byte == SWRST_CODE);
  assign wr_en    = cs_s && byte_done && (phase == PH_WR) && !is_guard;

  always_ff @(posedge clk) begin
    if (rst || !cs_s) begin
      phase     <= PH_CMD;
      addr_q    <= '0;
      load_pend <= 1'b0;
      swrst     <= 1'b0;
    end else begin
      swrst <= 1'b0;
      if (fall) load_pend <= 1'b0;
      if (byte_done) begin
        case (phase)
          PH_CMD: begin
            if (rx_byte[DW-2:AW] == SUB_VAL) begin
              addr_q <= rx_byte[AW-1:0];
              if (rx_byte[DW-1]) begin
                phase     <= PH_RD;
                load_pend <= 1'b1;
              end else begin
                phase <= PH_WR;
              end
            end else begin
              phase <= PH_IGN;
            end
          end
          PH_WR: begin
            addr_q <= addr_q + 1'b1;
            if (is_guard) swrst <= 1'b1;
          end
          PH_RD: begin
            addr_q    <= addr_q + 1'b1;
            load_pend <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr_q] <= rx_byte & IMPL_MASK[int'(addr_q)*DW +: DW];
    rd_q <= mem[addr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      miso_oe <= 1'b0;
      busy    <= 1'b0;
    end else begin
      miso_oe <= cs_s && (phase == PH_RD);
      busy    <= cs_s;
    end
  end

  assign miso = tx_bit & miso_oe;

  AST_SWRST_PULSE: assert property (@(posedge clk) disable iff (rst)
    swrst |=> !swrst); // R4
  AST_SWRST_ADDR0: assert property (@(posedge clk) disable iff (rst)
    swrst |-> ($past(addr_q) == '0)); // R4
  AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> busy); // R7
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (byte_done && cs_s && (phase == PH_WR || phase == PH_RD) && addr_q == '1)
      |=> (addr_q == '0)); // R3
  AST_IGN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IGN) |=> !miso_oe); // R9
endmodule

// File: tb/tb_spi_regbank.sv
module tb_spi_regbank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_en = 1'b0, sclk = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, busy, swrst;

  int checks = 0;
  int errors = 0;
  int swrst_cnt = 0;
  logic oe_seen = 1'b0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #5 clk = ~clk;

  spi_regbank dut (
    .clk(clk), .rst(rst), .cs_en(cs_en), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .busy(busy), .swrst(swrst)
  );

  always @(posedge clk) if (!rst && swrst) swrst_cnt <= swrst_cnt + 1;
  always @(negedge clk) if (miso_oe) oe_seen <= 1'b1;

  // addr, write data, expected read-back
  localparam logic [19:0] VEC [8] = '{
    {4'h2, 8'hA5, 8'hA5},
    {4'h5, 8'hFF, 8'h3F},
    {4'h6, 8'hFF, 8'h07},
    {4'h6, 8'hA9, 8'h01},
    {4'h0, 8'h59, 8'h59},
    {4'h1, 8'h58, 8'h58},
    {4'h9, 8'h3C, 8'h3C},
    {4'hF, 8'h81, 8'h81}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (6) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input int n);
    logic [7:0] dummy;
    cs_en = 1'b1;
    repeat (4) @(negedge clk);
    sbyte(cmd, dummy);
    for (int i = 0; i < n; i++) sbyte(wbuf[i], rbuf[i]);
    repeat (4) @(negedge clk);
    cs_en = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 oe", {7'd0, miso_oe}, 8'h00);
    chk("R11 busy", {7'd0, busy}, 8'h00);
    chk("R11 swrst", {7'd0, swrst}, 8'h00);

    // R10 access flag
    cs_en = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 busy high", {7'd0, busy}, 8'h01);
    cs_en = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 busy low", {7'd0, busy}, 8'h00);

    // vector table: R1 R2 R5 R6, plus R4 non-guard cases
    for (int v = 0; v < 8; v++) begin
      wbuf[0] = VEC[v][15:8];
      oe_seen = 1'b0;
      xfer({1'b0, 3'b001, VEC[v][19:16]}, 1);
      chk("R7 no drive on write", {7'd0, oe_seen}, 8'h00);
      wbuf[0] = 8'h00;
      xfer({1'b1, 3'b001, VEC[v][19:16]}, 1);
      chk("R2 R5 R6 readback", rbuf[0], VEC[v][7:0]);
    end
    chk("R4 no pulse for non-guard", swrst_cnt[7:0], 8'h00);

    // R3 burst write wrapping E,F,0
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    xfer({1'b0, 3'b001, 4'hE}, 3);
    xfer({1'b1, 3'b001, 4'hE}, 3);
    chk("R3 burst E", rbuf[0], 8'h11);
    chk("R3 burst F", rbuf[1], 8'h22);
    chk("R3 wrap to 0", rbuf[2], 8'h33);
    xfer({1'b1, 3'b001, 4'hF}, 2);
    chk("R1 start address F", rbuf[0], 8'h22);
    chk("R3 read wrap", rbuf[1], 8'h33);

    // R4 guarded reset
    wbuf[0] = 8'h58;
    xfer({1'b0, 3'b001, 4'h0}, 1);
    chk("R4 one pulse", swrst_cnt[7:0], 8'h01);
    xfer({1'b1, 3'b001, 4'h0}, 1);
    chk("R4 reg0 kept", rbuf[0], 8'h33);

    // R9 wrong subaddress
    wbuf[0] = 8'h00;
    oe_seen = 1'b0;
    xfer({1'b0, 3'b010, 4'h2}, 1);
    xfer({1'b1, 3'b011, 4'h2}, 1);
    chk("R9 never drives", {7'd0, oe_seen}, 8'h00);
    xfer({1'b1, 3'b001, 4'h2}, 1);
    chk("R9 reg2 untouched", rbuf[0], 8'hA5);

    // R8 abort mid-byte
    cs_en = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      mosi = 1'b1;
      repeat (6) @(negedge clk);
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_en = 1'b0;
    repeat (8) @(negedge clk);
    wbuf[0] = 8'h77;
    xfer({1'b0, 3'b001, 4'h9}, 1);
    xfer({1'b1, 3'b001, 4'h9}, 1);
    chk("R8 recovered after abort", rbuf[0], 8'h77);
    chk("R4 no extra pulse", swrst_cnt[7:0], 8'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule